// File: doc/BRIEF.md
# Maskable Interrupt Flag and Enable Controller

This block collects maskable interrupt requests from the rest of the chip and holds each one as a pending bit in one of two 16-bit flag registers. A pending bit is offered to the CPU only under four conditions: its enable bit is set, the global mask is clear, the interrupt has not yet been acknowledged, and, while the CPU is halted for real-time debugging, it is also marked time-critical in a debug-enable register. Among the eligible interrupts, the lowest vector number wins. The block reports that vector number together with a 24-bit vector address.

The vector address is a 16-bit page pointer followed by the vector number times eight. Vectors 16 to 23 take their page from a host pointer, and all other vectors take it from a core pointer. The register interface has three kinds of access. Software clears flags by writing ones, and writing back a value just read clears exactly those pending bits. Software can also write the enable, debug-enable, pointer and mask registers. When the CPU acknowledges the offered interrupt, its flag is cleared and the global mask is set, so the service routine starts with interrupts blocked.

Top module: `irq_hub`

## Requirements
- R1: A high bit on `irqReq[i]` at a clock edge sets pending flag i. Flag i is bit i%16 of flag register i/16, at address 0 for vectors 0-15 and address 1 for vectors 16-31. Reads of these addresses return the flags.
- R2: Writing a flag address clears the flags at the bit positions written as 1 and leaves the other flags unchanged. Writing back a value just read therefore clears all the pending bits it showed.
- R3: If a request and a write-one-to-clear hit the same flag in the same cycle, the flag is set afterwards.
- R4: Hardware reset (`rstN` low) clears all flags, enables (addresses 2, 3), debug enables (addresses 4, 5) and pointers (core at 6, host at 7), and sets the global mask to 1. A `swReset` pulse clears all flags and leaves the enables, debug enables, pointers and mask unchanged.
- R5: `irqValid` is 1 exactly when some flag is set whose enable bit is also set, while the global mask is 0. Once offered, an interrupt stays offered until it is acknowledged, cleared or disabled.
- R6: When several interrupts are eligible, `irqVector` gives the lowest-numbered one.
- R7: While `cpuHalted` is 1, an interrupt is eligible only if its debug-enable bit is also set.
- R8: `irqAddr` is {pointer, vector, 3'b000}. The pointer is the host pointer for vectors 16 to 23 and the core pointer for all other vectors.
- R9: `intAck` while `irqValid` is 1 clears the offered vector's flag (unless a new request for it arrives in the same cycle) and sets the global mask. `intAck` while `irqValid` is 0 changes nothing.
- R10: Writing address 8 loads the global mask from data bit 0. Reading address 8 returns the mask in bit 0. An acknowledge in the same cycle wins, leaving the mask at 1.
- R11: The bus-error, data-log and RTOS requests use bits 8, 9 and 10 of flag register 1, which are vectors 24, 25 and 26. They take their vector page from the core pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| swReset | input | 1 | Software reset pulse; clears flags only |
| irqReq | input | 32 | Interrupt request lines, one per vector |
| cpuHalted | input | 1 | CPU halted in real-time debug mode |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address for read and write |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Register read data, combinational from `regAddr` |
| intAck | input | 1 | CPU takes the offered interrupt |
| irqValid | output | 1 | An eligible interrupt is offered |
| irqVector | output | 5 | Number of the offered interrupt |
| irqAddr | output | 24 | Vector address of the offered interrupt |
| globalMask | output | 1 | Global mask state |

## Verification
Two pairs of functions can land on the same register in a single cycle. A new request can meet a software clear of the same flag, and an acknowledge can meet a software write of the global mask. The bench drives each pair of strobes in the same cycle. It then reads the flag register and observes `globalMask` in the cycle after. A behavioural model updates the same state every cycle, so it judges each outcome against the stated precedence: the request wins over the clear, and the acknowledge wins over the mask write.

// File: rtl/irq_hub_pkg.sv
`timescale 1ns/1ps
package irq_hub_pkg;

  // width of the bank index carried in the strobe bundle
  localparam int BANK_IDX_W = 4;

  // per-cycle strobes from control to datapath
  typedef struct packed {
    logic                  flagWr;   // write-one-to-clear on a flag bank
    logic                  enWr;     // load an enable bank
    logic                  dbgWr;    // load a debug-enable bank
    logic [BANK_IDX_W-1:0] bank;     // which bank the above address
    logic                  coreWr;   // load core page pointer
    logic                  hostWr;   // load host page pointer
    logic                  maskWr;   // load global mask from data bit 0
    logic                  ackTake;  // acknowledge of the offered interrupt
    logic                  swClr;    // software reset of the flags
  } strobe_t;

endpackage

// File: rtl/irq_hub_ctrl.sv
`timescale 1ns/1ps
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 4
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              intAck,
  input  logic              swReset,
  input  logic              irqValid,
  output strobe_t           st
);

  localparam logic [ADDR_W-1:0] EN_BASE   = ADDR_W'(NBANK);
  localparam logic [ADDR_W-1:0] DBG_BASE  = ADDR_W'(2 * NBANK);
  localparam logic [ADDR_W-1:0] CORE_ADDR = ADDR_W'(3 * NBANK);
  localparam logic [ADDR_W-1:0] HOST_ADDR = ADDR_W'(3 * NBANK + 1);
  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(3 * NBANK + 2);

  always_comb begin
    st = '0;
    if (regWrEn) begin
      if (regAddr < EN_BASE) begin
        st.flagWr = 1'b1;
        st.bank   = BANK_IDX_W'(regAddr);
      end else if (regAddr < DBG_BASE) begin
        st.enWr = 1'b1;
        st.bank = BANK_IDX_W'(regAddr - EN_BASE);
      end else if (regAddr < CORE_ADDR) begin
        st.dbgWr = 1'b1;
        st.bank  = BANK_IDX_W'(regAddr - DBG_BASE);
      end else if (regAddr == CORE_ADDR) begin
        st.coreWr = 1'b1;
      end else if (regAddr == HOST_ADDR) begin
        st.hostWr = 1'b1;
      end else if (regAddr == MASK_ADDR) begin
        st.maskWr = 1'b1;
      end
    end
    // an acknowledge only counts while something is being offered
    st.ackTake = intAck & irqValid;
    st.swClr   = swReset;
  end

endmodule

// File: rtl/irq_hub_dp.sv
`timescale 1ns/1ps
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int BANK_W  = 16,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int HOST_LO = 16,
  parameter int HOST_HI = 23,
  localparam int NUM    = NBANK * BANK_W,
  localparam int VEC_W  = $clog2(NUM),
  localparam int SLOT_W = VEC_W + 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 st,
  input  logic [NUM-1:0]          irqReq,
  input  logic                    cpuHalted,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [BANK_W-1:0]       wrData,
  output logic [BANK_W-1:0]       rdData,
  output logic                    irqValid,
  output logic [VEC_W-1:0]        irqVector,
  output logic [PTR_W+SLOT_W-1:0] irqAddr,
  output logic                    maskOut
);

  localparam logic [VEC_W-1:0]  HOST_FIRST = VEC_W'(HOST_LO);
  localparam logic [VEC_W-1:0]  HOST_LAST  = VEC_W'(HOST_HI);
  localparam logic [ADDR_W-1:0] CORE_ADDR  = ADDR_W'(3 * NBANK);
  localparam logic [ADDR_W-1:0] HOST_ADDR  = ADDR_W'(3 * NBANK + 1);
  localparam logic [ADDR_W-1:0] MASK_ADDR  = ADDR_W'(3 * NBANK + 2);

  logic [NUM-1:0]   flagQ, flagD;
  logic [NUM-1:0]   enQ, dbgQ;
  logic [NUM-1:0]   clrVec, ackVec, elig;
  logic [PTR_W-1:0] corePtrQ, hostPtrQ;
  logic             maskQ;
  logic [VEC_W-1:0] winVec;
  logic             isHost;

  // per-bank write decode and enable storage
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic              hit;
    logic [BANK_W-1:0] enB, dbgB;

    assign hit = (st.bank == BANK_IDX_W'(b));
    assign clrVec[b*BANK_W +: BANK_W] = (st.flagWr && hit) ? wrData : '0;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enB  <= '0;
        dbgB <= '0;
      end else begin
        if (st.enWr && hit)  enB  <= wrData;
        if (st.dbgWr && hit) dbgB <= wrData;
      end
    end

    assign enQ[b*BANK_W +: BANK_W]  = enB;
    assign dbgQ[b*BANK_W +: BANK_W] = dbgB;
  end

  // acknowledge clears the currently offered vector
  assign ackVec = st.ackTake ? (NUM'(1) << winVec) : '0;

  // new requests win over both kinds of clear
  always_comb begin
    if (st.swClr) flagD = '0;
    else          flagD = (flagQ & ~clrVec & ~ackVec) | irqReq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ    <= '0;
      corePtrQ <= '0;
      hostPtrQ <= '0;
      maskQ    <= 1'b1;
    end else begin
      flagQ <= flagD;
      if (st.coreWr) corePtrQ <= PTR_W'(wrData);
      if (st.hostWr) hostPtrQ <= PTR_W'(wrData);
      if (st.ackTake)     maskQ <= 1'b1;
      else if (st.maskWr) maskQ <= wrData[0];
    end
  end

  // eligibility: pending, enabled, unmasked, time-critical when halted
  always_comb begin
    if (maskQ) elig = '0;
    else       elig = flagQ & enQ & (cpuHalted ? dbgQ : {NUM{1'b1}});
  end

  // fixed priority, lowest index first
  always_comb begin
    logic found;
    found  = 1'b0;
    winVec = '0;
    for (int i = 0; i < NUM; i++) begin
      if (elig[i] && !found) begin
        winVec = VEC_W'(i);
        found  = 1'b1;
      end
    end
  end

  assign irqValid  = |elig;
  assign irqVector = winVec;
  assign isHost    = (winVec >= HOST_FIRST) && (winVec <= HOST_LAST);
  assign irqAddr   = {(isHost ? hostPtrQ : corePtrQ), winVec, 3'b000};
  assign maskOut   = maskQ;

  // register read mux
  always_comb begin
    rdData = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (regAddr == ADDR_W'(b))             rdData = flagQ[b*BANK_W +: BANK_W];
      if (regAddr == ADDR_W'(NBANK + b))     rdData = enQ[b*BANK_W +: BANK_W];
      if (regAddr == ADDR_W'(2 * NBANK + b)) rdData = dbgQ[b*BANK_W +: BANK_W];
    end
    if (regAddr == CORE_ADDR) rdData = BANK_W'(corePtrQ);
    if (regAddr == HOST_ADDR) rdData = BANK_W'(hostPtrQ);
    if (regAddr == MASK_ADDR) rdData = BANK_W'(maskQ);
  end

endmodule

// File: rtl/irq_hub.sv
`timescale 1ns/1ps
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int BANK_W  = 16,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int HOST_LO = 16,
  parameter int HOST_HI = 23,
  localparam int NUM    = NBANK * BANK_W,
  localparam int VEC_W  = $clog2(NUM),
  localparam int SLOT_W = VEC_W + 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    swReset,
  input  logic [NUM-1:0]          irqReq,
  input  logic                    cpuHalted,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [BANK_W-1:0]       regWrData,
  output logic [BANK_W-1:0]       regRdData,
  input  logic                    intAck,
  output logic                    irqValid,
  output logic [VEC_W-1:0]        irqVector,
  output logic [PTR_W+SLOT_W-1:0] irqAddr,
  output logic                    globalMask
);

  strobe_t stb;

  irq_hub_ctrl #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .intAck  (intAck),
    .swReset (swReset),
    .irqValid(irqValid),
    .st      (stb)
  );

  irq_hub_dp #(
    .NBANK(NBANK), .BANK_W(BANK_W), .PTR_W(PTR_W), .ADDR_W(ADDR_W),
    .HOST_LO(HOST_LO), .HOST_HI(HOST_HI)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .st       (stb),
    .irqReq   (irqReq),
    .cpuHalted(cpuHalted),
    .regAddr  (regAddr),
    .wrData   (regWrData),
    .rdData   (regRdData),
    .irqValid (irqValid),
    .irqVector(irqVector),
    .irqAddr  (irqAddr),
    .maskOut  (globalMask)
  );

endmodule

// File: rtl/irq_hub_chk.sv
`timescale 1ns/1ps
module irq_hub_chk #(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              swReset,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              maskBit,
  input logic              intAck,
  input logic              cpuHalted,
  input logic              irqValid,
  input logic              globalMask
);

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(3 * NBANK + 2);

  // R5
  keep_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqValid && !intAck && !swReset && !regWrEn)
      |=> (irqValid || (cpuHalted != $past(cpuHalted))));

  // R9
  ack_sets_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && irqValid) |=> globalMask);

  // R9
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !irqValid && !(regWrEn && regAddr == MASK_ADDR))
      |=> (globalMask == $past(globalMask)));

  // R10
  mask_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == MASK_ADDR && !(intAck && irqValid))
      |=> (globalMask == $past(maskBit)));

  // R4
  sw_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    swReset |=> !irqValid);

endmodule

bind irq_hub irq_hub_chk #(.NBANK(NBANK), .ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .swReset   (swReset),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .maskBit   (regWrData[0]),
  .intAck    (intAck),
  .cpuHalted (cpuHalted),
  .irqValid  (irqValid),
  .globalMask(globalMask)
);

// File: tb/test_irq_hub.sv
`timescale 1ns/1ps
module test_irq_hub;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        swReset = 1'b0;
  logic [31:0] irqReq = '0;
  logic        cpuHalted = 1'b0;
  logic        regWrEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        intAck = 1'b0;
  logic        irqValid;
  logic [4:0]  irqVector;
  logic [23:0] irqAddr;
  logic        globalMask;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  string curTag = "R4";

  always #2.5 clk = ~clk;

  irq_hub i_irq_hub (
    .clk(clk), .rstN(rstN), .swReset(swReset), .irqReq(irqReq),
    .cpuHalted(cpuHalted), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .intAck(intAck),
    .irqValid(irqValid), .irqVector(irqVector), .irqAddr(irqAddr),
    .globalMask(globalMask)
  );

  // ---------------- behavioural reference model ----------------
  bit [31:0] mFlag, mEn, mDbg;
  bit [15:0] mCore, mHost;
  bit        mMask = 1'b1;

  function automatic bit [31:0] mElig();
    if (mMask) return '0;
    return mFlag & mEn & (cpuHalted ? mDbg : 32'hFFFF_FFFF);
  endfunction

  function automatic int mVec();
    bit [31:0] e = mElig();
    for (int k = 0; k < 32; k++) if (e[k]) return k;
    return 0;
  endfunction

  function automatic bit [23:0] mAddr();
    int v = mVec();
    bit [15:0] p = (v >= 16 && v <= 23) ? mHost : mCore;
    return {p, 8'(v * 8)};
  endfunction

  function automatic bit [15:0] mRead(input bit [3:0] a);
    case (a)
      4'd0: return mFlag[15:0];
      4'd1: return mFlag[31:16];
      4'd2: return mEn[15:0];
      4'd3: return mEn[31:16];
      4'd4: return mDbg[15:0];
      4'd5: return mDbg[31:16];
      4'd6: return mCore;
      4'd7: return mHost;
      4'd8: return {15'd0, mMask};
      default: return 16'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mFlag = '0; mEn = '0; mDbg = '0; mCore = '0; mHost = '0; mMask = 1'b1;
    end else begin
      bit [31:0] nf;
      bit        v;
      int        w;
      v  = (mElig() != 0);
      w  = mVec();
      nf = mFlag;
      if (regWrEn && regAddr == 4'd0) nf[15:0]  = nf[15:0]  & ~regWrData;
      if (regWrEn && regAddr == 4'd1) nf[31:16] = nf[31:16] & ~regWrData;
      if (intAck && v) nf[w] = 1'b0;
      nf = nf | irqReq;
      if (swReset) nf = '0;
      if (regWrEn) begin
        case (regAddr)
          4'd2: mEn[15:0]   = regWrData;
          4'd3: mEn[31:16]  = regWrData;
          4'd4: mDbg[15:0]  = regWrData;
          4'd5: mDbg[31:16] = regWrData;
          4'd6: mCore = regWrData;
          4'd7: mHost = regWrData;
          4'd8: mMask = regWrData[0];
          default: ;
        endcase
      end
      if (intAck && v) mMask = 1'b1;
      mFlag = nf;
    end
  end

  // ---------------- checking ----------------
  task automatic checkVal(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareModel();
    checkVal(curTag, "irqValid", 32'(irqValid), 32'(mElig() != 0));
    if (mElig() != 0) begin
      checkVal(curTag, "irqVector", 32'(irqVector), 32'(mVec()));
      checkVal(curTag, "irqAddr", 32'(irqAddr), 32'(mAddr()));
    end
    checkVal(curTag, "globalMask", 32'(globalMask), 32'(mMask));
    checkVal(curTag, "regRdData", 32'(regRdData), 32'(mRead(regAddr)));
  endtask

  // one clock: inputs change at the falling edge, outputs judged 1 ns later
  task automatic step(input logic [31:0] req, input logic we, input logic [3:0] a,
                      input logic [15:0] d, input logic ack, input logic swr);
    @(negedge clk);
    irqReq = req; regWrEn = we; regAddr = a; regWrData = d;
    intAck = ack; swReset = swr;
    #1;
    compareModel();
  endtask

  task automatic idle(input logic [3:0] a);
    step('0, 1'b0, a, '0, 1'b0, 1'b0);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step('0, 1'b1, a, d, 1'b0, 1'b0);
  endtask

  task automatic pulse(input logic [31:0] req);
    step(req, 1'b0, 4'd0, '0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R4 reset state
    curTag = "R4";
    idle(4'd2);
    checkVal("R4", "mask at reset", 32'(globalMask), 32'd1);
    checkVal("R4", "valid at reset", 32'(irqValid), 32'd0);
    @(negedge clk); rstN = 1'b1;
    idle(4'd6);
    checkVal("R4", "core ptr at reset", 32'(regRdData), 32'd0);

    // configuration
    wr(4'd2, 16'hFFFF); wr(4'd3, 16'hFFFF);
    wr(4'd6, 16'h1234); wr(4'd7, 16'hABCD);
    wr(4'd8, 16'h0000);

    // R1 / R8 single request
    curTag = "R1";
    pulse(32'h0000_0020);
    idle(4'd0);
    checkVal("R1", "flag bank0", 32'(regRdData), 32'h0020);
    checkVal("R8", "vector 5 addr", 32'(irqAddr), 32'h123428);

    // R6 priority
    curTag = "R6";
    pulse(32'h0010_0008);
    idle(4'd0);
    checkVal("R6", "lowest wins", 32'(irqVector), 32'd3);
    wr(4'd0, 16'h0028);
    idle(4'd0);
    checkVal("R8", "host vector 20 addr", 32'(irqAddr), 32'hABCDA0);

    // R3 request and clear of the same bit together
    curTag = "R3";
    step(32'h0010_0000, 1'b1, 4'd1, 16'h0010, 1'b0, 1'b0);
    idle(4'd1);
    checkVal("R3", "request beats clear", 32'(regRdData), 32'h0010);

    // R2 write back what was read
    curTag = "R2";
    pulse(32'h0002_0004);
    idle(4'd1);
    checkVal("R2", "bank1 read", 32'(regRdData), 32'h0012);
    wr(4'd0, 16'h0004); wr(4'd1, 16'h0012);
    idle(4'd1);
    checkVal("R2", "cleared by write-back", 32'(regRdData), 32'h0000);
    checkVal("R2", "nothing offered", 32'(irqValid), 32'd0);

    // R7 halted: debug enables filter
    curTag = "R7";
    wr(4'd4, 16'h0200);
    pulse(32'h0000_0280);
    @(negedge clk); cpuHalted = 1'b1;
    idle(4'd0);
    checkVal("R7", "halted picks time-critical", 32'(irqVector), 32'd9);
    @(negedge clk); cpuHalted = 1'b0;
    idle(4'd0);
    checkVal("R7", "running picks lowest", 32'(irqVector), 32'd7);

    // R9 acknowledge
    curTag = "R9";
    step('0, 1'b0, 4'd0, '0, 1'b1, 1'b0);
    idle(4'd0);
    checkVal("R9", "ack clears flag", 32'(regRdData), 32'h0200);
    checkVal("R9", "ack sets mask", 32'(globalMask), 32'd1);
    step('0, 1'b0, 4'd0, '0, 1'b1, 1'b0);
    idle(4'd0);
    checkVal("R9", "ack ignored when idle", 32'(regRdData), 32'h0200);

    // R10 mask write against acknowledge
    curTag = "R10";
    wr(4'd8, 16'h0000);
    idle(4'd8);
    checkVal("R10", "mask read", 32'(regRdData), 32'd0);
    step('0, 1'b1, 4'd8, 16'h0000, 1'b1, 1'b0);
    idle(4'd0);
    checkVal("R10", "ack beats mask write", 32'(globalMask), 32'd1);
    checkVal("R10", "flag 9 cleared", 32'(regRdData), 32'h0000);

    // R11 fixed bank1 lines
    curTag = "R11";
    wr(4'd8, 16'h0000);
    pulse(32'h0700_0000);
    idle(4'd1);
    checkVal("R11", "bus error vector", 32'(irqVector), 32'd24);
    checkVal("R11", "bus error addr", 32'(irqAddr), 32'h1234C0);
    wr(4'd1, 16'h0100);
    idle(4'd1);
    checkVal("R11", "data-log addr", 32'(irqAddr), 32'h1234C8);
    wr(4'd1, 16'h0200);
    idle(4'd1);
    checkVal("R11", "rtos addr", 32'(irqAddr), 32'h1234D0);
    wr(4'd1, 16'h0400);

    // R8 host range edges
    curTag = "R8";
    pulse(32'h0080_0000);
    idle(4'd1);
    checkVal("R8", "vector 23 host page", 32'(irqAddr), 32'hABCDB8);
    pulse(32'h0000_8000);
    idle(4'd1);
    checkVal("R8", "vector 15 core page", 32'(irqAddr), 32'h123478);

    // R5 offer persists untouched
    curTag = "R5";
    idle(4'd1);
    checkVal("R5", "still offered", 32'(irqValid), 32'd1);

    // R4 software reset
    curTag = "R4";
    step('0, 1'b0, 4'd0, '0, 1'b0, 1'b1);
    idle(4'd2);
    checkVal("R4", "sw reset keeps enables", 32'(regRdData), 32'hFFFF);
    checkVal("R4", "sw reset drops offer", 32'(irqValid), 32'd0);
    idle(4'd1);
    checkVal("R4", "sw reset clears flags", 32'(regRdData), 32'h0000);

    // R4 hardware reset
    @(negedge clk); rstN = 1'b0;
    idle(4'd2);
    checkVal("R4", "hw reset clears enables", 32'(regRdData), 32'h0000);
    @(negedge clk); rstN = 1'b1;
    idle(4'd8);
    checkVal("R4", "hw reset sets mask", 32'(regRdData), 32'd1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule